// File: doc/BRIEF.md
# Asynchronous NAND Bus Cycle Sequencer

This block sits between a simple host request port and an 8-bit asynchronous NAND flash bus. Each accepted host request is a read or a write of one, two or four bytes. The block plays it out as a series of byte cycles on the flash pins. Each byte cycle has three timed phases: setup, strobe and hold. The host address picks the cycle type. One address bit marks a command-latch cycle and another marks an address-latch cycle. The two lowest address bits play no part, so every byte of a wide access goes to the same flash location. A further address bit selects the second die of a stacked package. A separate chip-select index picks one of the chip enables.

All phase lengths come from one packed 32-bit timing word. Reads and writes have their own setup, strobe and hold fields. A turnaround gap is placed only where the bus changes direction between two accesses. Read bytes are captured on the last clock of the read strobe and packed least-significant byte first. The open-drain ready/busy line shared by the flash devices is synchronised and shown in a status byte.

Top module: `nand_cycle_seq`

## Requirements
- R1: While reset is asserted and straight after it, `req_ready` is 1, every `nand_ce_n` bit is 1, `nand_we_n` and `nand_re_n` are 1, and `nand_ale`, `nand_cle`, `nand_die_sel`, `nand_dq_oe` and `rsp_valid` are 0.
- R2: Each setup, strobe and hold phase lasts its timing field value plus one clock. Writes use setup `cfg_word[29:26]`, strobe `[25:20]` and hold `[19:17]`. Reads use setup `[16:13]`, strobe `[12:7]` and hold `[6:4]`.
- R3: In a write byte cycle, `nand_dq_oe` is 1 and `nand_dq_o` carries the byte throughout setup, strobe and hold. `nand_we_n` is 0 only during the strobe phase. `nand_re_n` stays 1.
- R4: In a read byte cycle, `nand_re_n` is 0 only during the strobe phase, `nand_we_n` stays 1 and `nand_dq_oe` stays 0. `nand_dq_i` is sampled on the last clock of the strobe phase and at no other clock.
- R5: `req_size` 0 gives one byte cycle, 1 gives two, and 2 or 3 gives four. Byte cycles follow back to back with no gap. Write bytes are sent from `req_wdata[7:0]` upward. `req_addr[1:0]` has no effect on any pin.
- R6: Read byte k lands in `rsp_rdata[8k+7:8k]`, and bytes beyond the access size read as 0. `rsp_valid` pulses for one clock in the first idle cycle after the final hold of a read, and never for a write.
- R7: `nand_cle` equals `req_addr[4]`. `nand_ale` equals `req_addr[3]` unless bit 4 is also set, in which case the command latch wins and `nand_ale` is 0. Both are driven only during setup, strobe and hold.
- R8: During setup, strobe and hold, exactly the `nand_ce_n` bit indexed by `req_cs` is 0. All chip enables are 1 at every other time, including turnaround.
- R9: `nand_die_sel` equals `req_addr[DIE_BIT]` (default bit 12) during setup, strobe and hold, and is 0 otherwise.
- R10: When an access has the opposite direction to the previous one, `cfg_word[3:2]` plus one idle clocks come between acceptance and its first setup. No gap is inserted for the first access after reset or for an access in the same direction.
- R11: `status[0]` follows `nand_rb` through a two-flop synchroniser (1 means ready, reset value 0), so it changes on the second rising edge after the pin changes. `status[7:1]` are 0.
- R12: `cfg_word` bits 31, 30, 1 and 0 have no effect on any pin or on timing.
- R13: `req_ready` is 1 only while idle. A request is accepted when `req_valid` and `req_ready` are both 1. `req_valid` during an access has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word | input | 32 | Packed phase timing word |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Sequencer idle and able to accept |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Host byte address (latch-type and die bits) |
| req_size | input | 2 | Access size code: 0 byte, 1 half, 2/3 word |
| req_cs | input | CS_W | Chip-enable index |
| req_wdata | input | 32 | Write data, least-significant byte first |
| rsp_valid | output | 1 | One-clock pulse on read completion |
| rsp_rdata | output | 32 | Assembled read data |
| status | output | 8 | Bit 0: synchronised ready/busy |
| nand_ce_n | output | NUM_CS | Active-low chip enables |
| nand_ale | output | 1 | Address latch enable |
| nand_cle | output | 1 | Command latch enable |
| nand_we_n | output | 1 | Active-low write strobe |
| nand_re_n | output | 1 | Active-low read strobe |
| nand_die_sel | output | 1 | Second-die select line |
| nand_dq_o | output | 8 | Data bus out |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_i | input | 8 | Data bus in |
| nand_rb | input | 1 | Wired ready/busy, 1 = ready |

## Verification
The bench changes direction in both orders and also runs several accesses in a row in the same direction. A design that tracks direction wrongly would add a turnaround gap where none belongs, or leave one out, and every later pin would then fall out of step with the reference. On all clocks except the last strobe clock it drives junk on the data inputs. A sampler that is off by one clock, or that fills the wrong byte lane, therefore produces a visibly wrong word. It uses addresses with both latch bits set, with the low two bits set, and with the die bit set, and timing words whose unused bits are set. A design that lost the command-latch priority, or that decoded ignored bits, would then show wrong latch, enable or timing behaviour. It also holds a request high while an access is running, to catch a sequencer that re-accepts while busy.

// File: rtl/nseq_pkg.sv
package nseq_pkg;

  localparam int CNT_W     = 6;
  localparam int BUS_BYTES = 4;
  localparam int BUS_W     = BUS_BYTES * 8;
  localparam int LANE_IDX_W = $clog2(BUS_BYTES);

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_TURN   = 3'd1,
    ST_SETUP  = 3'd2,
    ST_STROBE = 3'd3,
    ST_HOLD   = 3'd4
  } seq_state_e;

  typedef struct packed {
    logic [3:0] setup;
    logic [5:0] strobe;
    logic [2:0] hold;
  } phase_t;

  typedef struct packed {
    phase_t     wr;
    phase_t     rd;
    logic [1:0] turn;
  } timing_t;

  // Index of the last byte cycle for a given size code.
  function automatic logic [LANE_IDX_W-1:0] last_lane(input logic [1:0] size_code);
    logic [LANE_IDX_W-1:0] r;
    case (size_code)
      2'd0:    r = LANE_IDX_W'(0);
      2'd1:    r = LANE_IDX_W'(1);
      default: r = LANE_IDX_W'(BUS_BYTES - 1);
    endcase
    return r;
  endfunction

endpackage

// File: rtl/nseq_cfg_decode.sv
module nseq_cfg_decode
  import nseq_pkg::*;
(
  input  logic [31:0] cfg_word,
  output timing_t     timing
);

  // Field positions are fixed by the timing word layout.
  always_comb begin
    timing.wr.setup  = cfg_word[29:26];
    timing.wr.strobe = cfg_word[25:20];
    timing.wr.hold   = cfg_word[19:17];
    timing.rd.setup  = cfg_word[16:13];
    timing.rd.strobe = cfg_word[12:7];
    timing.rd.hold   = cfg_word[6:4];
    timing.turn      = cfg_word[3:2];
  end

  // Strobe-mode, extended-wait and bus-size bits carry no meaning here.
  logic unused_cfg_bits;
  assign unused_cfg_bits = ^{cfg_word[31:30], cfg_word[1:0]};

endmodule

// File: rtl/nseq_phase_timer.sv
module nseq_phase_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign last = (cnt_q == '0);

endmodule

// File: rtl/nseq_rb_sync.sv
module nseq_rb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rb_async,
  output logic rb_sync
);

  logic [STAGES-1:0] sync_q, sync_d;

  generate
    if (STAGES == 1) begin : g_single
      assign sync_d = rb_async;
    end else begin : g_chain
      assign sync_d = {sync_q[STAGES-2:0], rb_async};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rb_sync = sync_q[STAGES-1];

endmodule

// File: rtl/nseq_rd_assembler.sv
module nseq_rd_assembler #(
  parameter int LANES = 4,
  parameter int IDX_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               capture,
  input  logic [IDX_W-1:0]   lane_idx,
  input  logic [7:0]         din,
  output logic [LANES*8-1:0] data
);

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [7:0] lane_q, lane_d;
      logic       lane_en;

      assign lane_en = clear || (capture && (lane_idx == IDX_W'(g)));

      always_comb begin
        lane_d = lane_q;
        if (clear) begin
          lane_d = 8'h00;
        end else if (lane_en) begin
          lane_d = din;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          lane_q <= 8'h00;
        end else if (lane_en) begin
          lane_q <= lane_d;
        end
      end

      assign data[g*8 +: 8] = lane_q;
    end
  endgenerate

endmodule

// File: rtl/nand_cycle_seq.sv
module nand_cycle_seq
  import nseq_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int NUM_CS  = 4,
  parameter int CS_W    = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
  parameter int ALE_BIT = 3,
  parameter int CLE_BIT = 4,
  parameter int DIE_BIT = 12,
  parameter int RB_SYNC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       cfg_word,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [CS_W-1:0]   req_cs,
  input  logic [BUS_W-1:0]  req_wdata,
  output logic              rsp_valid,
  output logic [BUS_W-1:0]  rsp_rdata,
  output logic [7:0]        status,
  output logic [NUM_CS-1:0] nand_ce_n,
  output logic              nand_ale,
  output logic              nand_cle,
  output logic              nand_we_n,
  output logic              nand_re_n,
  output logic              nand_die_sel,
  output logic [7:0]        nand_dq_o,
  output logic              nand_dq_oe,
  input  logic [7:0]        nand_dq_i,
  input  logic              nand_rb
);

  localparam int IDX_W = LANE_IDX_W;

  // ---------------------------------------------------------------
  // Timing word decode
  // ---------------------------------------------------------------
  timing_t tim_live;
  phase_t  req_phase;

  nseq_cfg_decode u_cfg (
    .cfg_word (cfg_word),
    .timing   (tim_live)
  );

  assign req_phase = req_write ? tim_live.wr : tim_live.rd;

  // ---------------------------------------------------------------
  // State
  // ---------------------------------------------------------------
  seq_state_e            state_q, state_d;
  logic [IDX_W-1:0]      lane_q, lane_d;
  logic [IDX_W-1:0]      lane_last_q;
  logic                  wr_q;
  logic                  ale_q, cle_q, die_q;
  logic [CS_W-1:0]       cs_q;
  logic [BUS_W-1:0]      wdata_q;
  phase_t                ph_q;
  logic                  prev_wr_q;
  logic                  have_prev_q;
  logic                  rsp_valid_q, rsp_valid_d;

  logic                  accept;
  logic                  finish;
  logic                  tmr_load;
  logic [CNT_W-1:0]      tmr_val;
  logic                  tmr_last;
  logic                  need_turn;
  logic                  rd_capture;

  assign need_turn = have_prev_q && (prev_wr_q != req_write);

  // ---------------------------------------------------------------
  // Next-state logic
  // ---------------------------------------------------------------
  always_comb begin
    state_d  = state_q;
    lane_d   = lane_q;
    accept   = 1'b0;
    finish   = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          accept   = 1'b1;
          tmr_load = 1'b1;
          lane_d   = '0;
          if (need_turn) begin
            state_d = ST_TURN;
            tmr_val = CNT_W'(tim_live.turn);
          end else begin
            state_d = ST_SETUP;
            tmr_val = CNT_W'(req_phase.setup);
          end
        end
      end
      ST_TURN: begin
        if (tmr_last) begin
          state_d  = ST_SETUP;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(ph_q.setup);
        end
      end
      ST_SETUP: begin
        if (tmr_last) begin
          state_d  = ST_STROBE;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(ph_q.strobe);
        end
      end
      ST_STROBE: begin
        if (tmr_last) begin
          state_d  = ST_HOLD;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(ph_q.hold);
        end
      end
      ST_HOLD: begin
        if (tmr_last) begin
          if (lane_q == lane_last_q) begin
            state_d = ST_IDLE;
            finish  = 1'b1;
          end else begin
            state_d  = ST_SETUP;
            lane_d   = lane_q + 1'b1;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(ph_q.setup);
          end
        end
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  assign rsp_valid_d = finish && !wr_q;
  assign rd_capture  = (state_q == ST_STROBE) && tmr_last && !wr_q;

  // ---------------------------------------------------------------
  // Registers
  // ---------------------------------------------------------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      lane_q      <= '0;
      rsp_valid_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      lane_q      <= lane_d;
      rsp_valid_q <= rsp_valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_last_q <= '0;
      wr_q        <= 1'b0;
      ale_q       <= 1'b0;
      cle_q       <= 1'b0;
      die_q       <= 1'b0;
      cs_q        <= '0;
      wdata_q     <= '0;
      ph_q        <= '0;
      prev_wr_q   <= 1'b0;
      have_prev_q <= 1'b0;
    end else if (accept) begin
      lane_last_q <= last_lane(req_size);
      wr_q        <= req_write;
      cle_q       <= req_addr[CLE_BIT];
      ale_q       <= req_addr[ALE_BIT] && !req_addr[CLE_BIT];
      die_q       <= req_addr[DIE_BIT];
      cs_q        <= req_cs;
      wdata_q     <= req_wdata;
      ph_q        <= req_phase;
      prev_wr_q   <= req_write;
      have_prev_q <= 1'b1;
    end
  end

  // ---------------------------------------------------------------
  // Sub-blocks
  // ---------------------------------------------------------------
  nseq_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .last     (tmr_last)
  );

  nseq_rd_assembler #(.LANES(BUS_BYTES), .IDX_W(IDX_W)) u_rdasm (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (accept),
    .capture  (rd_capture),
    .lane_idx (lane_q),
    .din      (nand_dq_i),
    .data     (rsp_rdata)
  );

  logic rb_synced;

  nseq_rb_sync #(.STAGES(RB_SYNC)) u_rbsync (
    .clk      (clk),
    .rst_n    (rst_n),
    .rb_async (nand_rb),
    .rb_sync  (rb_synced)
  );

  // ---------------------------------------------------------------
  // Pin drive
  // ---------------------------------------------------------------
  logic active;
  assign active = (state_q == ST_SETUP) || (state_q == ST_STROBE) || (state_q == ST_HOLD);

  generate
    for (genvar c = 0; c < NUM_CS; c++) begin : g_ce
      assign nand_ce_n[c] = !(active && (cs_q == CS_W'(c)));
    end
  endgenerate

  assign nand_ale     = active && ale_q;
  assign nand_cle     = active && cle_q;
  assign nand_die_sel = active && die_q;
  assign nand_we_n    = !((state_q == ST_STROBE) && wr_q);
  assign nand_re_n    = !((state_q == ST_STROBE) && !wr_q);
  assign nand_dq_oe   = active && wr_q;
  assign nand_dq_o    = nand_dq_oe ? wdata_q[lane_q*8 +: 8] : 8'h00;

  assign req_ready = (state_q == ST_IDLE);
  assign rsp_valid = rsp_valid_q;
  assign status    = {7'b0, rb_synced};

  logic unused_addr_bits;
  assign unused_addr_bits = ^req_addr;

endmodule

// File: rtl/nseq_chk.sv
module nseq_chk #(
  parameter int NUM_CS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [NUM_CS-1:0] nand_ce_n,
  input logic              nand_ale,
  input logic              nand_cle,
  input logic              nand_we_n,
  input logic              nand_re_n,
  input logic              nand_dq_oe
);

  // R3
  we_drives_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_we_n |-> nand_dq_oe);

  // R4
  re_releases_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_re_n |-> (!nand_dq_oe && nand_we_n));

  // R7
  latch_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_ale && nand_cle));

  // R8
  single_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~nand_ce_n) <= 1);

  // R8
  strobe_needs_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n || !nand_re_n) |-> !(&nand_ce_n));

  // R13
  ready_means_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> ((&nand_ce_n) && nand_we_n && nand_re_n && !nand_dq_oe));

  // R6
  rsp_in_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> req_ready);

  // R6
  rsp_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

endmodule

bind nand_cycle_seq nseq_chk #(.NUM_CS(NUM_CS)) u_nseq_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .nand_ce_n  (nand_ce_n),
  .nand_ale   (nand_ale),
  .nand_cle   (nand_cle),
  .nand_we_n  (nand_we_n),
  .nand_re_n  (nand_re_n),
  .nand_dq_oe (nand_dq_oe)
);

// File: tb/test_nand_cycle_seq.sv
`timescale 1ns/1ps
module test_nand_cycle_seq;

  localparam int ADDR_W = 24;
  localparam int NUM_CS = 4;
  localparam int CS_W   = 2;

  logic              clk;
  logic              rst_n;
  logic [31:0]       cfg_word;
  logic              req_valid;
  logic              req_ready;
  logic              req_write;
  logic [ADDR_W-1:0] req_addr;
  logic [1:0]        req_size;
  logic [CS_W-1:0]   req_cs;
  logic [31:0]       req_wdata;
  logic              rsp_valid;
  logic [31:0]       rsp_rdata;
  logic [7:0]        status;
  logic [NUM_CS-1:0] nand_ce_n;
  logic              nand_ale, nand_cle, nand_we_n, nand_re_n, nand_die_sel;
  logic [7:0]        nand_dq_o;
  logic              nand_dq_oe;
  logic [7:0]        nand_dq_i;
  logic              nand_rb;

  nand_cycle_seq i_nand_cycle_seq (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_cs(req_cs), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .status(status),
    .nand_ce_n(nand_ce_n), .nand_ale(nand_ale), .nand_cle(nand_cle),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_die_sel(nand_die_sel),
    .nand_dq_o(nand_dq_o), .nand_dq_oe(nand_dq_oe), .nand_dq_i(nand_dq_i),
    .nand_rb(nand_rb)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  typedef struct packed {
    logic [3:0] ce_n;
    logic       ale;
    logic       cle;
    logic       we_n;
    logic       re_n;
    logic       oe;
    logic [7:0] dq;
    logic       die;
    logic       rsp;
    logic       ready;
    logic [7:0] din;
  } exp_t;

  exp_t exp_q[$];
  logic [31:0] exp_rdata;
  bit          have_prev;
  bit          prev_wr;

  function automatic exp_t idle_exp();
    exp_t e;
    e.ce_n = 4'hF; e.ale = 0; e.cle = 0; e.we_n = 1; e.re_n = 1;
    e.oe = 0; e.dq = 8'h00; e.die = 0; e.rsp = 0; e.ready = 1; e.din = 8'h5A;
    return e;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    compared++;
    if (act !== expv) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, expv, $time);
    end
  endtask

  // One clock: compare outputs to the model, then drive the data input.
  task automatic step();
    exp_t e;
    @(negedge clk);
    e = (exp_q.size() > 0) ? exp_q.pop_front() : idle_exp();
    chk("R8 ce_n", 32'(nand_ce_n), 32'(e.ce_n));
    chk("R7 ale", 32'(nand_ale), 32'(e.ale));
    chk("R7 cle", 32'(nand_cle), 32'(e.cle));
    chk("R3 we_n", 32'(nand_we_n), 32'(e.we_n));
    chk("R4 re_n", 32'(nand_re_n), 32'(e.re_n));
    chk("R3 dq_oe", 32'(nand_dq_oe), 32'(e.oe));
    if (e.oe) chk("R5 dq_o byte", 32'(nand_dq_o), 32'(e.dq));
    chk("R9 die_sel", 32'(nand_die_sel), 32'(e.die));
    chk("R13 req_ready", 32'(req_ready), 32'(e.ready));
    chk("R6 rsp_valid", 32'(rsp_valid), 32'(e.rsp));
    if (e.rsp) chk("R6 rsp_rdata", rsp_rdata, exp_rdata);
    nand_dq_i = e.din;
  endtask

  task automatic push_phase(input int len, input exp_t base, input bit strobe,
                            input bit wr, input logic [7:0] rd_byte);
    for (int k = 0; k < len; k++) begin
      exp_t e = base;
      if (strobe) begin
        e.we_n = !wr;
        e.re_n = wr;
        if (!wr && k == len - 1) e.din = rd_byte;
      end
      exp_q.push_back(e);
    end
  endtask

  // Reference schedule for one access, built from the requirement text.
  task automatic push_access(input bit wr, input logic [ADDR_W-1:0] addr,
                             input logic [1:0] size, input logic [CS_W-1:0] cs,
                             input logic [31:0] wdata, input logic [31:0] rbytes);
    int nb;
    int su, sb, hd, ta;
    exp_t base;
    nb = (size == 0) ? 1 : (size == 1) ? 2 : 4;
    ta = int'((cfg_word >> 2) & 32'h3);
    if (wr) begin
      su = int'((cfg_word >> 26) & 32'hF);
      sb = int'((cfg_word >> 20) & 32'h3F);
      hd = int'((cfg_word >> 17) & 32'h7);
    end else begin
      su = int'((cfg_word >> 13) & 32'hF);
      sb = int'((cfg_word >> 7) & 32'h3F);
      hd = int'((cfg_word >> 4) & 32'h7);
    end
    if (have_prev && prev_wr != wr) begin
      for (int t = 0; t <= ta; t++) begin
        exp_t e = idle_exp();
        e.ready = 0;
        exp_q.push_back(e);
      end
    end
    have_prev = 1;
    prev_wr = wr;
    exp_rdata = 32'h0;
    for (int b = 0; b < nb; b++) begin
      base = idle_exp();
      base.ready = 0;
      base.ce_n = ~(4'b0001 << cs);
      base.cle = addr[4];
      base.ale = addr[3] && !addr[4];
      base.die = addr[12];
      base.oe = wr;
      base.dq = wr ? wdata[b*8 +: 8] : 8'h00;
      base.din = ~rbytes[b*8 +: 8];
      push_phase(su + 1, base, 0, wr, 8'h00);
      push_phase(sb + 1, base, 1, wr, rbytes[b*8 +: 8]);
      push_phase(hd + 1, base, 0, wr, 8'h00);
      if (!wr) exp_rdata[b*8 +: 8] = rbytes[b*8 +: 8];
    end
    begin
      exp_t e = idle_exp();
      e.rsp = !wr;
      exp_q.push_back(e);
    end
  endtask

  task automatic issue(input bit wr, input logic [ADDR_W-1:0] addr,
                       input logic [1:0] size, input logic [CS_W-1:0] cs,
                       input logic [31:0] wdata, input logic [31:0] rbytes);
    req_valid = 1; req_write = wr; req_addr = addr; req_size = size;
    req_cs = cs; req_wdata = wdata;
    push_access(wr, addr, size, cs, wdata, rbytes);
    step();
    req_valid = 0;
  endtask

  task automatic drain();
    while (exp_q.size() > 0) step();
    step();
  endtask

  function automatic logic [31:0] mk_cfg(int ws, int wst, int wh, int rs, int rst,
                                         int rh, int ta, logic [3:0] junk);
    return (32'(ws) << 26) | (32'(wst) << 20) | (32'(wh) << 17) | (32'(rs) << 13) |
           (32'(rst) << 7) | (32'(rh) << 4) | (32'(ta) << 2) |
           {junk[3:2], 28'h0, junk[1:0]};
  endfunction

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    rst_n = 0; req_valid = 0; req_write = 0; req_addr = '0; req_size = 0;
    req_cs = 0; req_wdata = 0; nand_dq_i = 8'h5A; nand_rb = 1;
    have_prev = 0; prev_wr = 0; exp_rdata = 0;
    cfg_word = mk_cfg(1, 2, 1, 0, 3, 0, 1, 4'h0);

    // R1: reset state on the pins
    repeat (3) step();
    rst_n = 1;
    repeat (2) step();

    // R3 R7 R2: single command-latch write byte on chip 0
    issue(1, 24'h000010, 2'd0, 2'd0, 32'h0000_00A7, 32'h0);
    drain();
    // R7 R8: address-latch write byte on chip 1
    issue(1, 24'h000008, 2'd0, 2'd1, 32'h0000_0033, 32'h0);
    drain();
    // R10 R4 R6 R5: four-byte read after a write (turnaround)
    issue(0, 24'h000000, 2'd2, 2'd2, 32'h0, 32'hC3B2_A190);
    drain();
    // R5: two-byte read, low address bits set, same direction (no gap)
    issue(0, 24'h000003, 2'd1, 2'd0, 32'h0, 32'h0000_7E15);
    drain();
    // R6: one-byte read, upper bytes zero
    issue(0, 24'h000000, 2'd0, 2'd3, 32'h0, 32'hFFFF_FF4C);
    drain();
    // R7 R9 R10: four-byte write, both latch bits, die bit, size code 3
    issue(1, 24'h001018, 2'd3, 2'd3, 32'h8877_6655, 32'h0);
    drain();
    // R5: two-byte write in same direction
    issue(1, 24'h000001, 2'd1, 2'd2, 32'hDEAD_BEEF, 32'h0);
    drain();

    // R11: ready/busy synchroniser latency
    nand_rb = 0;
    step();
    chk("R11 status old", 32'(status), 32'h01);
    step();
    chk("R11 status busy", 32'(status), 32'h00);
    nand_rb = 1;
    step();
    chk("R11 status still busy", 32'(status), 32'h00);
    step();
    chk("R11 status ready", 32'(status), 32'h01);

    // R12 R2: unused cfg bits set, longer read timings, turnaround 3
    cfg_word = mk_cfg(2, 1, 3, 2, 9, 2, 3, 4'hF);
    issue(0, 24'h000004, 2'd2, 2'd1, 32'h0, 32'h1122_3344);
    drain();
    // R10: write after read with turnaround 3
    issue(1, 24'h000000, 2'd0, 2'd0, 32'h0000_00C9, 32'h0);
    drain();

    // R13: request held high during a long write is ignored
    cfg_word = mk_cfg(0, 12, 0, 0, 0, 0, 2, 4'h0);
    issue(1, 24'h000010, 2'd0, 2'd1, 32'h0000_005E, 32'h0);
    req_valid = 1; req_write = 0; req_addr = 24'h000008; req_cs = 2'd3;
    repeat (4) step();
    req_valid = 0;
    drain();
    // R10: read follows, turnaround 2 (direction tracked from the write)
    issue(0, 24'h000000, 2'd1, 2'd0, 32'h0, 32'h0000_9A8B);
    drain();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule